// File: doc/BRIEF.md
# UART Channel Interrupt Mask and Sleep Unit

This block sits beside one serial channel. It takes the channel's raw event flags and the eight-bit interrupt enable register. From them it produces one masked interrupt line, the encoded level of the highest-priority pending source, a flag for a matched special character, and a request to gate off the channel clock. Several enable bits change meaning with the operating mode:
- In 9-bit framing, bit 2 also covers address characters.
- Bit 5 is a special-character enable in 9-bit framing and in enhanced mode. In the legacy alternate-sleep mode it is a second sleep enable.
- Bits 6 and 7 mask the RTS and CTS change events only in enhanced mode.

A small matcher compares each received character against four programmable values. It latches the result, and the address (ninth) bit, until the character is read out. The level output and the interrupt line are registered. The sleep request is registered from the same cycle's pending state.

Top module: `uart_irq_mask`

## Requirements
- R1: Enable bit 0 gates `ev_rx_ready`, bit 1 gates `ev_tx_empty` and bit 3 gates `ev_modem`. A 1 lets the source through and a 0 blocks it.
- R2: Enable bit 2 gates `ev_line_status`. When `nine_bit` is set, it also gates the latched address flag. That flag is set by a received character whose bit 8 is 1. Both sources report level 1.
- R3: With `nine_bit` set and enable bit 5 set, a received character equal in all nine bits to any of the four entries of `spc_chars` sets `spc_match`. Entry k occupies bits 9k+8..9k. The match reports level 3.
- R4: With `enh_mode` set, `nine_bit` clear and enable bit 5 set, only the low eight bits are compared. Entry 0 takes part only when `ibfc_en` is 1. Entry 1 takes part only when `xoff2_en` is 1. Entries 2 and 3 never match in this mode.
- R5: With both `enh_mode` and `nine_bit` clear, no special character is detected. If `alt_sleep_mode` is also 1, enable bit 5 acts as a sleep enable.
- R6: Enable bit 4 is the sleep enable. `sleep_req` is 1 one clock after a cycle in which sleep is enabled, no source is pending and `rx_idle` is 1. It drops one clock after any of those fails.
- R7: When `enh_mode` is 1, enable bits 6 and 7 gate `ev_rts` and `ev_cts`. When `enh_mode` is 0, both events are always enabled whatever bits 6 and 7 hold.
- R8: `irq` is 1 only when a source is pending and `glb_en` is 1. `irq_level` does not depend on `glb_en`.
- R9: `irq_level` gives the highest pending source one clock after its inputs. The codes are: 1 line status or address, 2 receive data, 3 special character, 4 transmitter empty, 5 modem, RTS or CTS, and 0 for none. All outputs are 0 in reset.
- R10: The match and address flags are captured on every `rx_char_valid` for that character. `rx_char_read` without `rx_char_valid` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier | input | 8 | Interrupt enable register |
| enh_mode | input | 1 | Enhanced mode active |
| nine_bit | input | 1 | 9-bit framing active |
| alt_sleep_mode | input | 1 | Legacy mode in which bit 5 is a second sleep enable |
| ibfc_en | input | 1 | In-band flow control configured (entry 0 active) |
| xoff2_en | input | 1 | Second stop character enabled (entry 1 active) |
| rx_char | input | 9 | Received character, bit 8 is the address bit |
| rx_char_valid | input | 1 | One-cycle strobe: new character received |
| rx_char_read | input | 1 | One-cycle strobe: character read out |
| spc_chars | input | 36 | Four special-character values, 9 bits each |
| ev_rx_ready | input | 1 | Receive data ready event |
| ev_tx_empty | input | 1 | Transmitter empty event |
| ev_line_status | input | 1 | Receive line status event |
| ev_modem | input | 1 | Modem status change event |
| ev_rts | input | 1 | RTS change event |
| ev_cts | input | 1 | CTS change event |
| rx_idle | input | 1 | Receiver idle |
| glb_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Masked interrupt line |
| irq_level | output | 3 | Highest pending source level |
| spc_match | output | 1 | Latched special-character match |
| sleep_req | output | 1 | Clock-gate request |

## Verification
The assertions assume the following about the inputs:
- Every input holds a known value on each rising edge.
- `rx_char_valid` and `rx_char_read` are single-cycle strobes from the receive path.
- Event flags are levels held by their sources.

The bench changes inputs only on falling edges and holds every input at 0 while reset is asserted. It then sweeps all 256 enable values against every mode combination and a rotating set of event patterns. Each directed character case pulses a strobe for exactly one cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NUM_SRC = 5;

    // enable register field positions
    localparam int EN_RXD   = 0;
    localparam int EN_TXE   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MDM   = 3;
    localparam int EN_SLEEP = 4;
    localparam int EN_SPC   = 5;
    localparam int EN_RTS   = 6;
    localparam int EN_CTS   = 7;

    typedef enum logic [2:0] {
        LVL_NONE = 3'd0,
        LVL_LINE = 3'd1,
        LVL_RXD  = 3'd2,
        LVL_SPC  = 3'd3,
        LVL_TXE  = 3'd4,
        LVL_MDM  = 3'd5
    } irq_lvl_e;

    typedef struct packed {
        logic     irq;
        irq_lvl_e lvl;
    } irq_state_t;

    typedef struct packed {
        logic spc;
        logic addr;
    } rx_flag_t;

endpackage

// File: rtl/uirq_spchar_match.sv
module uirq_spchar_match
    import uirq_pkg::*;
#(
    parameter int NUM_SPC = 4,
    parameter int CHAR_W  = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      det_en,
    input  logic                      nine_bit,
    input  logic                      enh_mode,
    input  logic                      ibfc_en,
    input  logic                      xoff2_en,
    input  logic [CHAR_W-1:0]         rx_char,
    input  logic                      rx_char_valid,
    input  logic                      rx_char_read,
    input  logic [NUM_SPC*CHAR_W-1:0] spc_chars,
    output logic                      spc_flag,
    output logic                      addr_flag
);

    localparam int DATA_W = CHAR_W - 1;

    logic [NUM_SPC-1:0] entry_act;
    logic [NUM_SPC-1:0] entry_hit;
    logic               hit_any;
    rx_flag_t           flag_d, flag_q;
    logic               past_valid_q;

    for (genvar g = 0; g < NUM_SPC; g++) begin : g_entry
        logic [CHAR_W-1:0] val;
        assign val = spc_chars[g*CHAR_W +: CHAR_W];
        if (g == 0) begin : g_first
            assign entry_act[g] = nine_bit | ibfc_en;
        end else if (g == 1) begin : g_second
            assign entry_act[g] = nine_bit | xoff2_en;
        end else begin : g_rest
            assign entry_act[g] = nine_bit;
        end
        assign entry_hit[g] = nine_bit ? (rx_char == val)
                                       : (rx_char[DATA_W-1:0] == val[DATA_W-1:0]);
    end

    assign hit_any = det_en && (nine_bit || enh_mode) && |(entry_act & entry_hit);

    always_comb begin
        flag_d = flag_q;
        if (rx_char_valid) begin
            flag_d.spc  = hit_any;
            flag_d.addr = nine_bit & rx_char[CHAR_W-1];
        end else if (rx_char_read) begin
            flag_d.spc  = 1'b0;
            flag_d.addr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q       <= '0;
            past_valid_q <= 1'b0;
        end else begin
            flag_q       <= flag_d;
            past_valid_q <= 1'b1;
        end
    end

    assign spc_flag  = flag_q.spc;
    assign addr_flag = flag_q.addr;

    // R10
    spc_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && $past(rx_char_read && !rx_char_valid)) |-> !spc_flag);

    // R5
    no_legacy_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && $past(rx_char_valid && !enh_mode && !nine_bit)) |-> !spc_flag);

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pending,
    output irq_lvl_e           lvl,
    output logic               any
);

    always_comb begin
        lvl = LVL_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pending[i]) begin
                lvl = irq_lvl_e'(3'(i + 1));
            end
        end
    end

    assign any = |pending;

endmodule

// File: rtl/uirq_sleep.sv
module uirq_sleep (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_en,
    input  logic alt_en,
    input  logic alt_sleep_mode,
    input  logic enh_mode,
    input  logic nine_bit,
    input  logic pending_any,
    input  logic rx_idle,
    output logic sleep_req
);

    logic sleep_d, sleep_q;
    logic past_valid_q;
    logic allow;

    always_comb begin
        allow   = sleep_en | (alt_en & alt_sleep_mode & ~enh_mode & ~nine_bit);
        sleep_d = allow & ~pending_any & rx_idle;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q      <= 1'b0;
            past_valid_q <= 1'b0;
        end else begin
            sleep_q      <= sleep_d;
            past_valid_q <= 1'b1;
        end
    end

    assign sleep_req = sleep_q;

    // R6
    sleep_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && sleep_req) |-> $past(rx_idle && !pending_any));

endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
    import uirq_pkg::*;
#(
    parameter int NUM_SPC = 4,
    parameter int CHAR_W  = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                ier,
    input  logic                      enh_mode,
    input  logic                      nine_bit,
    input  logic                      alt_sleep_mode,
    input  logic                      ibfc_en,
    input  logic                      xoff2_en,
    input  logic [CHAR_W-1:0]         rx_char,
    input  logic                      rx_char_valid,
    input  logic                      rx_char_read,
    input  logic [NUM_SPC*CHAR_W-1:0] spc_chars,
    input  logic                      ev_rx_ready,
    input  logic                      ev_tx_empty,
    input  logic                      ev_line_status,
    input  logic                      ev_modem,
    input  logic                      ev_rts,
    input  logic                      ev_cts,
    input  logic                      rx_idle,
    input  logic                      glb_en,
    output logic                      irq,
    output logic [2:0]                irq_level,
    output logic                      spc_match,
    output logic                      sleep_req
);

    logic               spc_flag, addr_flag;
    logic               spc_on, rts_on, cts_on;
    logic [NUM_SRC-1:0] pending;
    irq_lvl_e           top_lvl;
    logic               pending_any;
    irq_state_t         st_d, st_q;
    logic               past_valid_q;

    assign spc_on = ier[EN_SPC] & (nine_bit | enh_mode);

    uirq_spchar_match #(.NUM_SPC(NUM_SPC), .CHAR_W(CHAR_W)) u_match (
        .clk           (clk),
        .rst_n         (rst_n),
        .det_en        (ier[EN_SPC]),
        .nine_bit      (nine_bit),
        .enh_mode      (enh_mode),
        .ibfc_en       (ibfc_en),
        .xoff2_en      (xoff2_en),
        .rx_char       (rx_char),
        .rx_char_valid (rx_char_valid),
        .rx_char_read  (rx_char_read),
        .spc_chars     (spc_chars),
        .spc_flag      (spc_flag),
        .addr_flag     (addr_flag)
    );

    always_comb begin
        rts_on     = enh_mode ? ier[EN_RTS] : 1'b1;
        cts_on     = enh_mode ? ier[EN_CTS] : 1'b1;
        pending[0] = ier[EN_LINE] & (ev_line_status | (nine_bit & addr_flag));
        pending[1] = ier[EN_RXD] & ev_rx_ready;
        pending[2] = spc_on & spc_flag;
        pending[3] = ier[EN_TXE] & ev_tx_empty;
        pending[4] = (ier[EN_MDM] & ev_modem) | (rts_on & ev_rts) | (cts_on & ev_cts);
    end

    uirq_prio u_prio (
        .pending (pending),
        .lvl     (top_lvl),
        .any     (pending_any)
    );

    uirq_sleep u_sleep (
        .clk            (clk),
        .rst_n          (rst_n),
        .sleep_en       (ier[EN_SLEEP]),
        .alt_en         (ier[EN_SPC]),
        .alt_sleep_mode (alt_sleep_mode),
        .enh_mode       (enh_mode),
        .nine_bit       (nine_bit),
        .pending_any    (pending_any),
        .rx_idle        (rx_idle),
        .sleep_req      (sleep_req)
    );

    always_comb begin
        st_d     = st_q;
        st_d.lvl = top_lvl;
        st_d.irq = pending_any & glb_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '{irq: 1'b0, lvl: LVL_NONE};
            past_valid_q <= 1'b0;
        end else begin
            st_q         <= st_d;
            past_valid_q <= 1'b1;
        end
    end

    assign irq       = st_q.irq;
    assign irq_level = st_q.lvl;
    assign spc_match = spc_flag;

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && irq) |-> $past(glb_en));

    // R1
    rxd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && irq_level == 3'd2) |-> $past(ier[0] && ev_rx_ready));

    // R7
    rts_cts_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && $past(!enh_mode && (ev_rts || ev_cts))) |-> irq_level != 3'd0);

    // R9
    line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && $past(ier[2] && ev_line_status)) |-> irq_level == 3'd1);

    // R6
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> irq_level == 3'd0);

endmodule

// File: tb/uart_irq_mask_tb.sv
`timescale 1ns/1ps
module uart_irq_mask_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ier = '0;
    logic        enh_mode = 0, nine_bit = 0, alt_sleep_mode = 0;
    logic        ibfc_en = 0, xoff2_en = 0;
    logic [8:0]  rx_char = '0;
    logic        rx_char_valid = 0, rx_char_read = 0;
    logic [35:0] spc_chars;
    logic        ev_rx_ready = 0, ev_tx_empty = 0, ev_line_status = 0;
    logic        ev_modem = 0, ev_rts = 0, ev_cts = 0;
    logic        rx_idle = 0, glb_en = 0;
    logic        irq, spc_match, sleep_req;
    logic [2:0]  irq_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // entries: 0 -> 011, 1 -> 013, 2 -> 07E, 3 -> 155
    assign spc_chars = {9'h155, 9'h07E, 9'h013, 9'h011};

    always #4 clk = ~clk;

    uart_irq_mask u_dut (
        .clk(clk), .rst_n(rst_n), .ier(ier), .enh_mode(enh_mode),
        .nine_bit(nine_bit), .alt_sleep_mode(alt_sleep_mode),
        .ibfc_en(ibfc_en), .xoff2_en(xoff2_en), .rx_char(rx_char),
        .rx_char_valid(rx_char_valid), .rx_char_read(rx_char_read),
        .spc_chars(spc_chars), .ev_rx_ready(ev_rx_ready),
        .ev_tx_empty(ev_tx_empty), .ev_line_status(ev_line_status),
        .ev_modem(ev_modem), .ev_rts(ev_rts), .ev_cts(ev_cts),
        .rx_idle(rx_idle), .glb_en(glb_en), .irq(irq),
        .irq_level(irq_level), .spc_match(spc_match), .sleep_req(sleep_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_lvl(input logic [7:0] e, input logic enh, input logic nb,
                                   input logic [5:0] ev, input logic spc, input logic adr);
        logic rts_ok, cts_ok;
        rts_ok = enh ? e[6] : 1'b1;
        cts_ok = enh ? e[7] : 1'b1;
        // ev: 0 rx_ready, 1 tx_empty, 2 line, 3 modem, 4 rts, 5 cts
        if (e[2] && (ev[2] || (nb && adr))) return 1;
        if (e[0] && ev[0]) return 2;
        if (spc && e[5] && (nb || enh)) return 3;
        if (e[1] && ev[1]) return 4;
        if ((e[3] && ev[3]) || (rts_ok && ev[4]) || (cts_ok && ev[5])) return 5;
        return 0;
    endfunction

    task automatic send_char(input logic [8:0] c);
        @(negedge clk);
        rx_char = c; rx_char_valid = 1'b1;
        @(negedge clk);
        rx_char_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_char();
        @(negedge clk);
        rx_char_read = 1'b1;
        @(negedge clk);
        rx_char_read = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        chk("R9 reset irq", irq, 0);
        chk("R9 reset level", irq_level, 0);
        chk("R9 reset spc", spc_match, 0);
        chk("R6 reset sleep", sleep_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: every enable value x every mode x rotating event patterns
        for (int e = 0; e < 256; e++) begin
            for (int m = 0; m < 8; m++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] p;
                    int el;
                    int es;
                    logic slp_ok;
                    p = 8'((e * 7 + m * 29 + k * 53) % 256);
                    ier = 8'(e);
                    enh_mode = m[0]; nine_bit = m[1]; alt_sleep_mode = m[2];
                    {ev_cts, ev_rts, ev_modem, ev_line_status, ev_tx_empty, ev_rx_ready} = p[5:0];
                    glb_en = p[6];
                    rx_idle = p[7];
                    @(negedge clk);
                    el = exp_lvl(8'(e), m[0], m[1], p[5:0], 1'b0, 1'b0);
                    slp_ok = ier[4] | (m[2] & ~m[0] & ~m[1] & ier[5]);
                    es = (slp_ok && el == 0 && p[7]) ? 1 : 0;
                    // R1 R2 R7 R9 levels across modes
                    chk("R1/R7/R9 sweep level", irq_level, el);
                    // R8 global gate
                    chk("R8 sweep irq", irq, (el != 0 && p[6]) ? 1 : 0);
                    // R5 R6 sleep enables
                    chk("R6 sweep sleep", sleep_req, es);
                end
            end
        end

        // directed character cases
        {ev_cts, ev_rts, ev_modem, ev_line_status, ev_tx_empty, ev_rx_ready} = '0;
        glb_en = 1; rx_idle = 0; alt_sleep_mode = 0;
        enh_mode = 0; nine_bit = 1; ier = 8'h20;
        read_char();
        send_char(9'h07E);
        chk("R3 nine-bit match flag", spc_match, 1);
        chk("R3 nine-bit match level", irq_level, 3);
        chk("R3 nine-bit match irq", irq, 1);
        send_char(9'h17E);
        chk("R3 ninth bit differs flag", spc_match, 0);
        chk("R2 address masked by bit2", irq_level, 0);
        ier = 8'h24;
        send_char(9'h155);
        chk("R3 entry3 match", spc_match, 1);
        chk("R2 address over special", irq_level, 1);
        read_char();
        chk("R10 read clears flag", spc_match, 0);
        chk("R10 read clears address", irq_level, 0);

        nine_bit = 0; enh_mode = 1; ier = 8'h20; ibfc_en = 1; xoff2_en = 0;
        send_char(9'h011);
        chk("R4 entry0 match", spc_match, 1);
        chk("R4 entry0 level", irq_level, 3);
        send_char(9'h013);
        chk("R4 entry1 off, R10 overwrite", spc_match, 0);
        xoff2_en = 1;
        send_char(9'h113);
        chk("R4 entry1 low-byte match", spc_match, 1);
        send_char(9'h07E);
        chk("R4 entry2 unused", spc_match, 0);
        ibfc_en = 0;
        send_char(9'h011);
        chk("R4 entry0 off", spc_match, 0);

        enh_mode = 0; ibfc_en = 1;
        send_char(9'h011);
        chk("R5 legacy no detect", spc_match, 0);
        chk("R5 legacy no level", irq_level, 0);

        // R5 alternate sleep
        rx_idle = 1; alt_sleep_mode = 1; ier = 8'h20;
        @(negedge clk);
        chk("R5 alt sleep on", sleep_req, 1);
        enh_mode = 1;
        @(negedge clk);
        chk("R5 alt sleep off in enhanced", sleep_req, 0);
        enh_mode = 0; alt_sleep_mode = 0; ier = 8'h10;
        @(negedge clk);
        chk("R6 sleep on", sleep_req, 1);
        rx_idle = 0;
        @(negedge clk);
        chk("R6 sleep drops after busy", sleep_req, 0);
        rx_idle = 1;
        @(negedge clk);
        chk("R6 sleep back", sleep_req, 1);
        ier = 8'h12; ev_tx_empty = 1;
        @(negedge clk);
        chk("R6 sleep drops on pending", sleep_req, 0);
        chk("R9 one-clock latency", irq_level, 4);
        glb_en = 0;
        @(negedge clk);
        chk("R8 masked irq", irq, 0);
        chk("R8 level kept", irq_level, 4);
        ev_rts = 1; ier = 8'h00; ev_tx_empty = 0;
        @(negedge clk);
        chk("R7 rts forced legacy", irq_level, 5);
        enh_mode = 1;
        @(negedge clk);
        chk("R7 rts masked enhanced", irq_level, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule